// File: doc/BRIEF.md
# Bus Wait-State Generator

This block stretches CPU bus accesses by a number of wait cycles that depends on the memory region addressed, on the access width (16 or 32 bit) and on whether the access continues a sequential burst. The region is the top byte of the bus address. A 16-bit timing-control register sets the wait counts of the three cartridge windows and of the battery-backed save memory. The other regions have fixed costs. The register also holds a prefetch-enable flag, which the block only stores and drives out.

A requester raises `req` for one cycle with the region, width and sequential flag. If the looked-up cost is zero, `ready` rises in that same cycle. Otherwise the block counts the cost down and pulses `ready` for one cycle exactly that many cycles after the request. It ignores new requests while it is counting.

Top module: `wait_state_gen`

## Requirements
- R1: After reset the control register reads 0, `prefetch_en` is 0 and `ready` is low while no request is present.
- R2: A write stores all 16 bits and they read back unchanged on `cfg_rdata` from the next cycle on. `prefetch_en` follows bit 14 of the register.
- R3: Each cartridge lane has a 2-bit first-access code: lane 0 at bits [3:2] for regions 8 and 9, lane 1 at bits [6:5] for regions 10 and 11, lane 2 at bits [9:8] for regions 12 and 13. The 16-bit non-sequential cost for codes 0, 1, 2, 3 is 4, 3, 2, 8 cycles.
- R4: Each cartridge lane has a sequential bit: bit 4 for lane 0, bit 7 for lane 1, bit 10 for lane 2. When the bit is 1 the 16-bit sequential cost is 1. When it is 0 the cost is 2 for lane 0, 4 for lane 1 and 8 for lane 2.
- R5: For every region below 16, a 32-bit non-sequential access costs first16 + seq16 + 1, and a 32-bit sequential access costs 2*seq16 + 1.
- R6: Region 14 (save memory) takes its 16-bit cost from the code in bits [1:0], using the same 4/3/2/8 mapping, for both sequential and non-sequential access. Its 32-bit cost is 2*value + 1.
- R7: Regions 9, 11 and 13 always cost the same as regions 8, 10 and 12.
- R8: Region 2 has a fixed 16-bit cost of 2, both sequential and non-sequential. Regions 0, 1, 3 to 7 and 15 have a 16-bit cost of 0. Every region index of 16 or above costs 0 at both widths.
- R9: A request whose cost is 0 raises `ready` combinationally in the cycle of the request.
- R10: A request with cost N > 0 keeps `ready` low for the N-1 cycles after the request cycle. It then raises `ready` for exactly one cycle, N cycles after the request.
- R11: A request presented while a countdown is running is ignored and does not change when `ready` rises.
- R12: A register write changes only the accesses that start after the write cycle. A request in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the timing-control register |
| cfg_wdata | input | 16 | Write data for the control register |
| cfg_rdata | output | 16 | Current control register contents |
| prefetch_en | output | 1 | Stored prefetch-enable flag (register bit 14) |
| req | input | 1 | Access request, one cycle |
| req_region | input | REGION_W (8) | Region index, the top address byte |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_seq | input | 1 | 1 = sequential access |
| ready | output | 1 | Access completion strobe |

## Verification
The bench builds the block with its defaults: 16 table regions and an 8-bit region input. With an 8-bit input, indices from 16 up to 255 can be driven, so the zero-cost path outside the table is exercised alongside the in-table regions. One control value sets a different code in every lane, sets the save-memory field to its longest code and sets the unused bits, so a single pass checks that the field positions are kept apart and reaches the largest cost of 17 cycles. Reset values cover the default timings, including the 1-cycle 32-bit cost of otherwise free regions.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  localparam int COST_W   = 5;
  localparam int MAX_COST = 17;

  typedef logic [COST_W-1:0] cost_t;

  typedef enum logic [2:0] {
    RK_FIXED = 3'd0,
    RK_LANE0 = 3'd1,
    RK_LANE1 = 3'd2,
    RK_LANE2 = 3'd3,
    RK_SAVE  = 3'd4
  } region_kind_e;

  localparam int SAVE_CODE_LSB = 0;
  localparam int PREFETCH_BIT  = 14;

  // Which timing source a table region uses
  function automatic region_kind_e kind_of(input int idx);
    case (idx)
      8, 9:    return RK_LANE0;
      10, 11:  return RK_LANE1;
      12, 13:  return RK_LANE2;
      14:      return RK_SAVE;
      default: return RK_FIXED;
    endcase
  endfunction

  // Low bit of the first-access code for a cartridge lane
  function automatic int lane_first_lsb(input int lane);
    case (lane)
      0:       return 2;
      1:       return 5;
      default: return 8;
    endcase
  endfunction

  // 2-bit code to first-access wait count
  function automatic cost_t first_wait(input logic [1:0] code);
    case (code)
      2'd0:    return cost_t'(4);
      2'd1:    return cost_t'(3);
      2'd2:    return cost_t'(2);
      default: return cost_t'(8);
    endcase
  endfunction

  // Sequential wait: fast bit gives 1, otherwise 2, 4 or 8 by lane
  function automatic cost_t seq_wait(input int lane, input logic fast);
    if (fast) return cost_t'(1);
    return cost_t'(2 << lane);
  endfunction

  // Costs of regions that are not programmable
  function automatic cost_t fixed_wait(input int idx);
    return (idx == 2) ? cost_t'(2) : cost_t'(0);
  endfunction

  function automatic cost_t cost32_first(input cost_t n16, input cost_t s16);
    return n16 + s16 + cost_t'(1);
  endfunction

  function automatic cost_t cost32_seq(input cost_t s16);
    return (s16 << 1) + cost_t'(1);
  endfunction

endpackage

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg #(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/wsg_cost_table.sv
module wsg_cost_table
  import wsg_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int REGION_W    = 8,
  parameter int CTRL_W      = 16
) (
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic [REGION_W-1:0] region,
  input  logic                wide,
  input  logic                seq,
  output cost_t               cost
);
  localparam int IDX_W = $clog2(NUM_REGIONS);

  cost_t n16 [NUM_REGIONS];
  cost_t s16 [NUM_REGIONS];
  cost_t n32 [NUM_REGIONS];
  cost_t s32 [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    localparam region_kind_e K = kind_of(g);
    if (K == RK_SAVE) begin : g_save
      assign n16[g] = first_wait(ctrl[SAVE_CODE_LSB +: 2]);
      assign s16[g] = first_wait(ctrl[SAVE_CODE_LSB +: 2]);
    end else if (K == RK_FIXED) begin : g_fixed
      assign n16[g] = fixed_wait(g);
      assign s16[g] = fixed_wait(g);
    end else begin : g_lane
      localparam int LANE = int'(K) - int'(RK_LANE0);
      localparam int FL   = lane_first_lsb(LANE);
      assign n16[g] = first_wait(ctrl[FL +: 2]);
      assign s16[g] = seq_wait(LANE, ctrl[FL + 2]);
    end
    assign n32[g] = cost32_first(n16[g], s16[g]);
    assign s32[g] = cost32_seq(s16[g]);
  end

  logic             in_range;
  logic [IDX_W-1:0] idx;
  assign in_range = region < REGION_W'(NUM_REGIONS);
  assign idx      = region[IDX_W-1:0];

  always_comb begin
    if (!in_range)  cost = '0;
    else if (wide)  cost = seq ? s32[idx] : n32[idx];
    else            cost = seq ? s16[idx] : n16[idx];
  end

  logic unused_ctrl;
  assign unused_ctrl = ^ctrl[CTRL_W-1:11];
endmodule

// File: rtl/wsg_sequencer.sv
module wsg_sequencer
  import wsg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  cost_t cost,
  output logic  ready,
  output logic  busy,
  output cost_t remaining,
  output logic  launch,
  output logic  finish
);
  logic zero_hit;

  assign launch   = req && !busy && (cost != '0);
  assign zero_hit = req && !busy && (cost == '0);
  assign finish   = busy && (remaining == cost_t'(1));
  assign ready    = zero_hit || finish;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      remaining <= cost;
    end else if (finish) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (busy) begin
      remaining <= remaining - cost_t'(1);
    end
  end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
  import wsg_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int REGION_W    = 8,
  parameter int CTRL_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CTRL_W-1:0]   cfg_wdata,
  output logic [CTRL_W-1:0]   cfg_rdata,
  output logic                prefetch_en,
  input  logic                req,
  input  logic [REGION_W-1:0] req_region,
  input  logic                req_wide,
  input  logic                req_seq,
  output logic                ready
);
  cost_t cost;
  cost_t remaining;
  logic  busy;
  logic  launch;
  logic  finish;

  wsg_ctrl_reg #(.CTRL_W(CTRL_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_rdata)
  );

  assign prefetch_en = cfg_rdata[PREFETCH_BIT];

  wsg_cost_table #(
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_W    (REGION_W),
    .CTRL_W      (CTRL_W)
  ) u_table (
    .ctrl   (cfg_rdata),
    .region (req_region),
    .wide   (req_wide),
    .seq    (req_seq),
    .cost   (cost)
  );

  wsg_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cost      (cost),
    .ready     (ready),
    .busy      (busy),
    .remaining (remaining),
    .launch    (launch),
    .finish    (finish)
  );
endmodule

// File: rtl/wait_state_gen_chk.sv
module wait_state_gen_chk
  import wsg_pkg::*;
#(
  parameter int REGION_W = 8,
  parameter int CTRL_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic [CTRL_W-1:0]   cfg_wdata,
  input logic [CTRL_W-1:0]   cfg_rdata,
  input logic                prefetch_en,
  input logic                req,
  input logic [REGION_W-1:0] req_region,
  input logic                ready,
  input logic                busy,
  input cost_t               remaining,
  input logic                launch,
  input logic                finish,
  input cost_t               cost
);
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R2
  hold_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R2
  prefetch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_en == cfg_rdata[14]);

  // R10
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && remaining == $past(cost));

  // R11
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> busy && remaining == $past(remaining) - cost_t'(1));

  // R10
  finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy && !$past(launch));

  // R8
  far_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy && req_region >= REGION_W'(16) |-> ready);

  // R5
  cost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cost <= cost_t'(MAX_COST));
endmodule

bind wait_state_gen wait_state_gen_chk #(.REGION_W(REGION_W), .CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/wait_state_gen_bench.sv
module wait_state_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        prefetch_en;
  logic        req = 1'b0;
  logic [7:0]  req_region = '0;
  logic        req_wide = 1'b0;
  logic        req_seq = 1'b0;
  logic        ready;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  wait_state_gen u_wait_state_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .prefetch_en(prefetch_en), .req(req),
    .req_region(req_region), .req_wide(req_wide), .req_seq(req_seq),
    .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_wait(input int code);
    int tab [4] = '{4, 3, 2, 8};
    return tab[code & 3];
  endfunction

  // Behavioural cost from the requirement text
  function automatic int bcost(input int r, input int rg, input bit w, input bit s);
    int n = 0, q = 0;
    if (rg >= 16) return 0;
    if (rg == 2) begin n = 2; q = 2; end
    else if (rg == 8 || rg == 9) begin
      n = code_wait(r >> 2); q = ((r >> 4) & 1) ? 1 : 2;
    end else if (rg == 10 || rg == 11) begin
      n = code_wait(r >> 5); q = ((r >> 7) & 1) ? 1 : 4;
    end else if (rg == 12 || rg == 13) begin
      n = code_wait(r >> 8); q = ((r >> 10) & 1) ? 1 : 8;
    end else if (rg == 14) begin
      n = code_wait(r); q = n;
    end
    if (w) return s ? 2 * q + 1 : n + q + 1;
    return s ? q : n;
  endfunction

  // Cycle reference model
  int m_reg = 0;
  bit m_busy = 0;
  int m_rem = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_busy = 0; m_rem = 0;
    end else begin
      int c;
      c = bcost(m_reg, req_region, req_wide, req_seq);
      if (!m_busy) begin
        if (req && c > 0) begin m_busy = 1; m_rem = c; end
      end else if (m_rem == 1) m_busy = 0;
      else m_rem--;
      if (cfg_we) m_reg = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rdy;
      exp_rdy = (!m_busy && req && bcost(m_reg, req_region, req_wide, req_seq) == 0)
                || (m_busy && m_rem == 1);
      chk(ready == exp_rdy, {cur_tag, " ready vs model"}, ready, exp_rdy);
      chk(cfg_rdata == m_reg[15:0], "R2 readback vs model", cfg_rdata, m_reg);
      chk(prefetch_en == m_reg[14], "R2 prefetch vs model", prefetch_en, m_reg[14]);
    end
  end

  task automatic wr(input logic [15:0] v);
    @(posedge clk); #1;
    cur_tag = "R2"; cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Issue one access and measure cycles until ready
  task automatic acc(input int rg, input bit w, input bit s, input int expn,
                     input string tag, input bit hold = 0);
    int lat;
    @(posedge clk); #1;
    cur_tag = tag; req = 1'b1; req_region = 8'(rg); req_wide = w; req_seq = s;
    @(negedge clk);
    if (expn == 0) begin
      chk(ready == 1'b1, {tag, " zero-cost same-cycle ready"}, ready, 1);
      @(posedge clk); #1; req = 1'b0;
    end else begin
      chk(ready == 1'b0, {tag, " no early ready"}, ready, 0);
      @(posedge clk); #1;
      if (hold) req_region = 8'h20;
      else req = 1'b0;
      lat = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        lat++;
        if (ready) break;
      end
      chk(lat == expn, {tag, " latency"}, lat, expn);
      @(posedge clk); #1; req = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 16'h0, "R1 reset register", cfg_rdata, 0);
    chk(prefetch_en == 1'b0, "R1 reset prefetch", prefetch_en, 0);
    chk(ready == 1'b0, "R1 idle ready", ready, 0);

    // Reset-value timings: R3 code 0, R4 slow seq, R5, R6, R8
    acc(8, 0, 0, 4, "R3");
    acc(8, 0, 1, 2, "R4");
    acc(10, 0, 1, 4, "R4");
    acc(12, 0, 1, 8, "R4");
    acc(8, 1, 0, 7, "R5");
    acc(8, 1, 1, 5, "R5");
    acc(14, 0, 1, 4, "R6");
    acc(14, 1, 0, 9, "R6");
    acc(2, 0, 0, 2, "R8");
    acc(2, 1, 0, 5, "R8");
    acc(0, 0, 0, 0, "R9");
    acc(15, 0, 1, 0, "R9");
    acc(0, 1, 0, 1, "R10");
    acc(8'h40, 1, 0, 0, "R8");
    acc(8'hFF, 0, 1, 0, "R8");

    // R11 request held during countdown
    acc(8, 0, 0, 4, "R11", 1);

    // Every first-access code on lane 0 (R3)
    for (int c = 0; c < 4; c++) begin
      wr(16'(c << 2));
      acc(8, 0, 0, code_wait(c), "R3");
    end

    // Mixed programming value
    wr(16'hCF57);
    @(negedge clk);
    chk(cfg_rdata == 16'hCF57, "R2 full readback", cfg_rdata, 16'hCF57);
    chk(prefetch_en == 1'b1, "R2 prefetch bit", prefetch_en, 1);
    acc(8, 0, 0, 3, "R3");
    acc(9, 0, 0, 3, "R7");
    acc(8, 0, 1, 1, "R4");
    acc(8, 1, 0, 5, "R5");
    acc(9, 1, 1, 3, "R7");
    acc(10, 0, 0, 2, "R3");
    acc(10, 0, 1, 4, "R4");
    acc(11, 1, 1, 9, "R7");
    acc(12, 0, 0, 8, "R3");
    acc(12, 1, 0, 10, "R5");
    acc(13, 1, 1, 3, "R7");
    acc(14, 0, 0, 8, "R6");
    acc(14, 1, 1, 17, "R6");
    acc(2, 0, 1, 2, "R8");

    // R12 write in the request cycle uses the old value
    @(posedge clk); #1;
    cur_tag = "R12"; cfg_we = 1'b1; cfg_wdata = 16'h0000;
    req = 1'b1; req_region = 8'd12; req_wide = 1'b0; req_seq = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0; req = 1'b0;
    begin
      int lat = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ready) break;
        lat++;
      end
      chk(lat == 8, "R12 old timing for same-cycle request", lat, 8);
    end
    acc(12, 0, 0, 4, "R12");

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule